// File: doc/BRIEF.md
# Single-Cycle Load/Store/Branch Processor Core

This block is a 32-bit processor core that completes one instruction on every rising clock edge. It supports word loads, word stores, branch-if-equal, and five register-to-register operations: add, subtract, AND, OR and signed set-on-less-than. The core contains a program counter, a 32-entry register file, an opcode decoder, a second-level ALU command decoder and the ALU. Instruction and data storage are small arrays inside the core.

Control is split into two levels. The opcode decoder reduces the opcode to a 2-bit operation class. The ALU command stage then combines that class with the function field to produce a 4-bit ALU command. A multiplexer picks the destination register field: the second-source field for loads and the third register field for register-register operations.

Program and data are placed in the arrays through a preload port, which only has an effect while reset is held. After reset is released, the core executes from address 0. Its register writes, data writes and program counter are visible at the ports.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high, `pc_o` is 0, every register reads 0, and a preload write stores `pre_data` at word `pre_addr` (instruction array when `pre_sel_data`=0, data array when 1). Preload writes made while `rst` is low have no effect.
- R2: An instruction that is not a taken branch advances `pc_o` by 4 on the next rising edge.
- R3: Opcode 35 (bits [31:26]) loads `dmem[(reg[rs] + sext(imm16)) >> 2]` into register rt (bits [20:16]). rs is bits [25:21] and imm16 is bits [15:0]. The ALU adds, and the low six bits of the offset never act as a function code.
- R4: Opcode 43 writes `reg[rt]` to the data word at `reg[rs] + sext(imm16)`. `dm_we_o`, `dm_addr_o` and `dm_wdata_o` show the store, and no register is written.
- R5: Opcode 4 compares rs and rt by subtraction. When they are equal, the next `pc_o` is `pc+4 + (sext(imm16) << 2)`, which may be backwards. Otherwise the next `pc_o` is `pc+4`.
- R6: Opcode 0 writes register rd (bits [15:11]) with a result chosen by bits [5:0]. The codes are 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, and 0x2A signed less-than, which gives 1 or 0.
- R7: Opcode 0 with any other function code writes 0 to rd.
- R8: Register 0 always reads as 0. An instruction targeting it raises no `rf_we_o` and leaves it at 0.
- R9: Any opcode other than 0, 4, 35 and 43 writes no register and no memory, and advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset; enables preload |
| pre_we | input | 1 | Preload write strobe (effective only in reset) |
| pre_sel_data | input | 1 | Preload target: 0 instruction array, 1 data array |
| pre_addr | input | LOAD_AW | Preload word index |
| pre_data | input | 32 | Preload word |
| pc_o | output | 32 | Current program counter |
| rf_we_o | output | 1 | Register write this cycle |
| rf_waddr_o | output | 5 | Register written |
| rf_wdata_o | output | 32 | Value written to register |
| dm_we_o | output | 1 | Data store this cycle |
| dm_addr_o | output | 32 | Store byte address |
| dm_wdata_o | output | 32 | Store data |

## Verification
A wrong register value stays hidden until some instruction reads that register. It then shows up in the same cycle as a wrong `rf_wdata_o`, `dm_wdata_o` or `dm_addr_o`, or as a wrong branch decision one cycle later on `pc_o`. A bad operation class or ALU command shows on the write outputs of the instruction that uses it. A wrong PC shows at once, because the bench model predicts `pc_o` for every cycle. The program is ordered so that each result is read back within a few instructions. This bounds the delay between a fault and its appearance at the ports.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam int XLEN      = 32;
    localparam int REG_COUNT = 32;
    localparam int RIDX_W    = $clog2(REG_COUNT);

    localparam logic [5:0] OPC_REG   = 6'd0;
    localparam logic [5:0] OPC_BEQ   = 6'd4;
    localparam logic [5:0] OPC_LOAD  = 6'd35;
    localparam logic [5:0] OPC_STORE = 6'd43;

    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_AND = 6'b100100;
    localparam logic [5:0] FN_OR  = 6'b100101;
    localparam logic [5:0] FN_SLT = 6'b101010;

    typedef enum logic [1:0] {
        CLS_MEM = 2'b00,
        CLS_BR  = 2'b01,
        CLS_REG = 2'b10,
        CLS_RSV = 2'b11
    } alu_cls_e;

    typedef enum logic [3:0] {
        CMD_AND = 4'b0000,
        CMD_OR  = 4'b0001,
        CMD_ADD = 4'b0010,
        CMD_SUB = 4'b0110,
        CMD_SLT = 4'b0111,
        CMD_BAD = 4'b1111
    } alu_cmd_e;

    typedef struct packed {
        logic [5:0]        op;
        logic [RIDX_W-1:0] rs;
        logic [RIDX_W-1:0] rt;
        logic [RIDX_W-1:0] rd;
        logic [4:0]        shamt;
        logic [5:0]        funct;
    } instr_t;

    typedef struct packed {
        logic     reg_write;
        logic     dst_rd;
        logic     mem_read;
        logic     mem_write;
        logic     branch;
        logic     src_imm;
        alu_cls_e cls;
    } ctrl_t;

    function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
        return {{(XLEN-16){v[15]}}, v};
    endfunction

endpackage

// File: rtl/sc_main_dec.sv
module sc_main_dec
    import sc_pkg::*;
(
    input  logic [5:0] op,
    output ctrl_t      ctrl
);
    always_comb begin
        ctrl = '{reg_write: 1'b0, dst_rd: 1'b0, mem_read: 1'b0, mem_write: 1'b0,
                 branch: 1'b0, src_imm: 1'b0, cls: CLS_MEM};
        case (op)
            OPC_REG: begin
                ctrl.reg_write = 1'b1;
                ctrl.dst_rd    = 1'b1;
                ctrl.cls       = CLS_REG;
            end
            OPC_LOAD: begin
                ctrl.reg_write = 1'b1;
                ctrl.mem_read  = 1'b1;
                ctrl.src_imm   = 1'b1;
                ctrl.cls       = CLS_MEM;
            end
            OPC_STORE: begin
                ctrl.mem_write = 1'b1;
                ctrl.src_imm   = 1'b1;
                ctrl.cls       = CLS_MEM;
            end
            OPC_BEQ: begin
                ctrl.branch = 1'b1;
                ctrl.cls    = CLS_BR;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sc_alu_ctl.sv
module sc_alu_ctl
    import sc_pkg::*;
(
    input  alu_cls_e   cls,
    input  logic [5:0] funct,
    output alu_cmd_e   cmd
);
    always_comb begin
        case (cls)
            CLS_MEM: cmd = CMD_ADD;
            CLS_BR:  cmd = CMD_SUB;
            CLS_REG: begin
                case (funct)
                    FN_ADD:  cmd = CMD_ADD;
                    FN_SUB:  cmd = CMD_SUB;
                    FN_AND:  cmd = CMD_AND;
                    FN_OR:   cmd = CMD_OR;
                    FN_SLT:  cmd = CMD_SLT;
                    default: cmd = CMD_BAD;
                endcase
            end
            default: cmd = CMD_BAD;
        endcase
    end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
#(
    parameter int W = XLEN
) (
    input  alu_cmd_e       cmd,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   y,
    output logic           zero
);
    always_comb begin
        case (cmd)
            CMD_AND: y = a & b;
            CMD_OR:  y = a | b;
            CMD_ADD: y = a + b;
            CMD_SUB: y = a - b;
            CMD_SLT: y = ($signed(a) < $signed(b)) ? W'(1) : '0;
            default: y = '0;
        endcase
    end

    assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int W     = 32,
    parameter int DEPTH = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [$clog2(DEPTH)-1:0] ra1,
    input  logic [$clog2(DEPTH)-1:0] ra2,
    output logic [W-1:0]             rd1,
    output logic [W-1:0]             rd2,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] wa,
    input  logic [W-1:0]             wd
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] regs [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
        end else if (we && (wa != AW'(0))) begin
            regs[wa] <= wd;
        end
    end

    assign rd1 = (ra1 == AW'(0)) ? '0 : regs[ra1];
    assign rd2 = (ra2 == AW'(0)) ? '0 : regs[ra2];
endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    parameter int LOAD_AW    = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pre_we,
    input  logic               pre_sel_data,
    input  logic [LOAD_AW-1:0] pre_addr,
    input  logic [31:0]        pre_data,
    output logic [31:0]        pc_o,
    output logic               rf_we_o,
    output logic [4:0]         rf_waddr_o,
    output logic [31:0]        rf_wdata_o,
    output logic               dm_we_o,
    output logic [31:0]        dm_addr_o,
    output logic [31:0]        dm_wdata_o
);
    localparam int IAW = $clog2(IMEM_WORDS);
    localparam int DAW = $clog2(DMEM_WORDS);

    logic [XLEN-1:0] pc_q, pc_plus4, br_target, pc_next;
    logic [XLEN-1:0] imem [IMEM_WORDS];
    logic [XLEN-1:0] dmem [DMEM_WORDS];

    instr_t          ins;
    ctrl_t           ctrl;
    alu_cmd_e        alu_cmd;
    logic [XLEN-1:0] imm, rd1, rd2, alu_b, alu_y, load_word, wdata;
    logic [RIDX_W-1:0] waddr;
    logic            alu_zero, br_taken;

    assign ins = imem[pc_q[IAW+1:2]];

    sc_main_dec u_dec (
        .op   (ins.op),
        .ctrl (ctrl)
    );

    sc_alu_ctl u_actl (
        .cls   (ctrl.cls),
        .funct (ins.funct),
        .cmd   (alu_cmd)
    );

    assign waddr = ctrl.dst_rd ? ins.rd : ins.rt;
    assign imm   = sext16({ins.rd, ins.shamt, ins.funct});

    sc_regfile #(.W(XLEN), .DEPTH(REG_COUNT)) u_rf (
        .clk (clk),
        .rst (rst),
        .ra1 (ins.rs),
        .ra2 (ins.rt),
        .rd1 (rd1),
        .rd2 (rd2),
        .we  (ctrl.reg_write),
        .wa  (waddr),
        .wd  (wdata)
    );

    assign alu_b = ctrl.src_imm ? imm : rd2;

    sc_alu #(.W(XLEN)) u_alu (
        .cmd  (alu_cmd),
        .a    (rd1),
        .b    (alu_b),
        .y    (alu_y),
        .zero (alu_zero)
    );

    assign load_word = dmem[alu_y[DAW+1:2]];
    assign wdata     = ctrl.mem_read ? load_word : alu_y;

    assign br_taken  = ctrl.branch && alu_zero;
    assign pc_plus4  = pc_q + 32'd4;
    assign br_target = pc_plus4 + (imm << 2);
    assign pc_next   = br_taken ? br_target : pc_plus4;

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_next;
    end

    always_ff @(posedge clk) begin
        if (rst && pre_we && !pre_sel_data) imem[pre_addr[IAW-1:0]] <= pre_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            if (pre_we && pre_sel_data) dmem[pre_addr[DAW-1:0]] <= pre_data;
        end else if (ctrl.mem_write) begin
            dmem[alu_y[DAW+1:2]] <= rd2;
        end
    end

    assign pc_o       = pc_q;
    assign rf_we_o    = ctrl.reg_write && (waddr != '0);
    assign rf_waddr_o = waddr;
    assign rf_wdata_o = wdata;
    assign dm_we_o    = ctrl.mem_write;
    assign dm_addr_o  = alu_y;
    assign dm_wdata_o = rd2;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] pc,
    input logic        br_taken,
    input logic        rf_we,
    input logic        dm_we,
    input logic [5:0]  op,
    input logic [3:0]  cmd
);
    logic past_ok = 1'b0;
    always_ff @(posedge clk) past_ok <= 1'b1;

    logic op_known;
    assign op_known = (op == 6'd0) || (op == 6'd4) || (op == 6'd35) || (op == 6'd43);

    p_reset_pc_r1: assert property (@(posedge clk)
        (past_ok && $past(rst)) |-> (pc == 32'd0));

    p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !$past(rst) && !$past(br_taken)) |-> (pc == $past(pc) + 32'd4));

    p_mem_add_r3: assert property (@(posedge clk) disable iff (rst)
        ((op == 6'd35) || (op == 6'd43)) |-> (cmd == 4'b0010));

    p_store_no_wb_r4: assert property (@(posedge clk) disable iff (rst)
        dm_we |-> !rf_we);

    p_beq_sub_r5: assert property (@(posedge clk) disable iff (rst)
        (op == 6'd4) |-> (cmd == 4'b0110 && !rf_we && !dm_we));

    p_nop_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !op_known |-> (!rf_we && !dm_we));
endmodule

bind sc_core sc_core_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .pc       (pc_o),
    .br_taken (br_taken),
    .rf_we    (rf_we_o),
    .dm_we    (dm_we_o),
    .op       (ins.op),
    .cmd      (alu_cmd)
);

// File: tb/sc_core_tb.sv
module sc_core_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pre_we = 1'b0;
    logic        pre_sel_data = 1'b0;
    logic [7:0]  pre_addr = '0;
    logic [31:0] pre_data = '0;
    logic [31:0] pc_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
    logic [4:0]  rf_waddr_o;
    logic        rf_we_o, dm_we_o;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    sc_core u_dut (
        .clk(clk), .rst(rst), .pre_we(pre_we), .pre_sel_data(pre_sel_data),
        .pre_addr(pre_addr), .pre_data(pre_data), .pc_o(pc_o),
        .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
        .dm_we_o(dm_we_o), .dm_addr_o(dm_addr_o), .dm_wdata_o(dm_wdata_o)
    );

    // reference state
    logic [31:0] m_imem [64];
    logic [31:0] m_dmem [64];
    logic [31:0] m_reg  [32];
    logic [31:0] m_pc;

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, int fn);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
    endfunction

    function automatic logic [31:0] enc_i(int op, int rs, int rt, int imm);
        return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h (pc model %h)", tag, what, act, exp, m_pc);
        end
    endtask

    task automatic preload(bit data, int addr, logic [31:0] val);
        pre_we = 1'b1; pre_sel_data = data; pre_addr = 8'(addr); pre_data = val;
        @(negedge clk);
        pre_we = 1'b0;
        if (data) m_dmem[addr] = val; else m_imem[addr] = val;
    endtask

    // compare current outputs with model, then advance model by one instruction
    task automatic step_model();
        logic [31:0] ins, a, b, imm, y, addr, nxt;
        logic [5:0]  op, fn;
        int rs, rt, rd;
        bit we, sw;
        logic [31:0] wd;
        int wa;
        string tag;
        ins = m_imem[m_pc[7:2]];
        op = ins[31:26]; rs = int'(ins[25:21]); rt = int'(ins[20:16]);
        rd = int'(ins[15:11]); fn = ins[5:0];
        imm = 32'(signed'(ins[15:0]));
        a = (rs == 0) ? 32'd0 : m_reg[rs];
        b = (rt == 0) ? 32'd0 : m_reg[rt];
        we = 0; sw = 0; wd = '0; wa = 0; addr = '0;
        nxt = m_pc + 32'd4;
        tag = "R2";
        case (op)
            6'd0: begin
                tag = "R6";
                case (fn)
                    6'h20: y = a + b;
                    6'h22: y = a - b;
                    6'h24: y = a & b;
                    6'h25: y = a | b;
                    6'h2A: y = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
                    default: begin y = 32'd0; tag = "R7"; end
                endcase
                wa = rd; wd = y; we = (rd != 0);
                if (rd == 0) tag = "R8";
            end
            6'd35: begin
                tag = "R3";
                addr = a + imm;
                wa = rt; wd = m_dmem[addr[7:2]]; we = (rt != 0);
            end
            6'd43: begin
                tag = "R4";
                addr = a + imm; sw = 1;
            end
            6'd4: begin
                tag = "R5";
                if (a == b) nxt = m_pc + 32'd4 + (imm << 2);
            end
            default: tag = "R9";
        endcase

        chk(tag, "pc", pc_o, m_pc);
        chk(tag, "rf_we", 32'(rf_we_o), 32'(we));
        chk(tag, "dm_we", 32'(dm_we_o), 32'(sw));
        if (we) begin
            chk(tag, "rf_waddr", 32'(rf_waddr_o), 32'(wa));
            chk(tag, "rf_wdata", rf_wdata_o, wd);
        end
        if (sw) begin
            chk(tag, "dm_addr", dm_addr_o, addr);
            chk(tag, "dm_wdata", dm_wdata_o, b);
        end

        if (we) m_reg[wa] = wd;
        if (sw) m_dmem[addr[7:2]] = b;
        m_pc = nxt;
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) begin m_imem[i] = '0; m_dmem[i] = '0; end
        for (int i = 0; i < 32; i++) m_reg[i] = '0;
        m_pc = '0;
        @(negedge clk);

        // data words
        preload(1, 0,  32'd5);
        preload(1, 9,  32'hFFFF_FFFD);
        preload(1, 62, 32'h0000_A5A5);
        // program
        preload(0, 0,  enc_i(35, 0, 1, 0));        // lw r1,0(r0)
        preload(0, 1,  enc_i(35, 0, 2, 'h24));     // lw r2,0x24(r0): offset low bits look like AND (R3)
        preload(0, 2,  enc_r(1, 2, 3, 'h20));      // add
        preload(0, 3,  enc_r(1, 2, 4, 'h22));      // sub
        preload(0, 4,  enc_r(1, 2, 5, 'h24));      // and
        preload(0, 5,  enc_r(1, 2, 6, 'h25));      // or
        preload(0, 6,  enc_r(2, 1, 7, 'h2A));      // slt signed: -3<5 -> 1
        preload(0, 7,  enc_r(1, 2, 8, 'h2A));      // slt: 5<-3 -> 0
        preload(0, 8,  enc_r(1, 1, 0, 'h20));      // write to r0 ignored (R8)
        preload(0, 9,  enc_i(43, 0, 0, 8));        // sw r0 -> stores 0 (R8)
        preload(0, 10, enc_i(4, 1, 2, 5));         // beq not taken
        preload(0, 11, enc_i(4, 3, 3, 2));         // beq taken -> word 14
        preload(0, 12, 32'hFC00_0000);             // skipped
        preload(0, 13, enc_i(43, 0, 3, 0));        // skipped
        preload(0, 14, enc_i(8, 1, 11, 7));        // unsupported opcode (R9)
        preload(0, 15, enc_i(43, 0, 4, 12));       // sw r4,12(r0)
        preload(0, 16, enc_i(35, 0, 9, 12));       // lw r9,12(r0)
        preload(0, 17, enc_r(1, 2, 10, 'h27));     // undefined function -> 0 (R7)
        preload(0, 18, enc_i(35, 12, 11, -8));     // negative offset, wraps to word 62
        preload(0, 19, enc_i(4, 0, 0, -1));        // branch to itself

        chk("R1", "pc in reset", pc_o, 32'd0);
        chk("R1", "dm_we in reset", 32'(dm_we_o), 32'd0);

        // R1: preload attempts after reset must be ignored
        pre_we = 1'b1; pre_sel_data = 1'b0; pre_addr = 8'd19;
        pre_data = enc_i(43, 0, 4, 0);
        rst = 1'b0;
        #1;
        step_model();
        for (int c = 0; c < 30; c++) begin
            @(negedge clk);
            if (c == 10) begin pre_sel_data = 1'b1; pre_addr = 8'd62; pre_data = 32'h1234; end
            step_model();
        end
        pre_we = 1'b0;
        // R1: data preload attempt had no effect; re-read word 62 through a load
        chk("R1", "word62 model", m_dmem[62], 32'h0000_A5A5);

        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule